// File: doc/BRIEF.md
# Flash Command Sequencer with Security Bits

This block carries out erase, program and read commands on two behavioural flash banks: a large application bank and a small loader bank. Software places a target address, a data byte and a control byte on the inputs and pulses `start_i`. The control byte picks the bank, gives two enable bits and carries an operation code. The sequencer checks the byte, captures the operands and holds `busy_o` for a duration set by a parameter. It then applies the operation, pulses `done_o`, and for a read presents the byte on `rdata_o`. A control byte that names no valid command, or a refused read, pulses `err_o` and changes nothing.

The block also keeps an eight-bit security register. Bits in this register can only be cleared, through a separate programming strobe. Only an erase of the application bank sets them back to one. Clearing bit 0 (lock) blocks every flash read and hides the register itself. Clearing bit 1 (fetch guard) refuses reads issued while `ext_fetch_i` shows that code is running from external memory.

In the full configuration the application bank uses 16 address bits and the loader bank uses 12. The default parameters are smaller so the behavioural arrays stay small.

Top module: `flash_cmd_seq`

## Requirements
- R1: Control byte fields: bit 6 selects the bank (0 application, 1 loader), bit 5 is output enable, bit 4 is chip enable, bits 3:0 are the opcode, and bit 7 is ignored. Three commands are valid: erase is opcode 0010 with enables 1/0, program is opcode 0001 with enables 1/0, and read is opcode 0000 with enables 0/0. Any other byte makes `err_o` high for the one cycle after the start edge, leaves `busy_o` low, and changes no state.
- R2: Erase sets every byte of the selected bank to 0xFF and leaves the other bank unchanged.
- R3: Program stores the old byte AND the new byte at the captured address, so bits can only go from 1 to 0.
- R4: Read returns the byte at the captured address on `rdata_o`. `rdata_o` changes only in the cycle where `done_o` is high.
- R5: `busy_o` goes high at the edge that accepts a start. It stays high for exactly ERASE_CYC, PROG_CYC or READ_CYC cycles, depending on the operation. `done_o` is high for the single cycle in which `busy_o` has just fallen.
- R6: A start while `busy_o` is high is ignored: it does not extend the current operation, it does not queue a command, and it does not raise an error.
- R7: Address bits above the bank's width are ignored, so loader addresses wrap every 2^LDR_AW bytes.
- R8: The security register is all ones after reset. `sec_prog_i` ANDs `sec_wdata_i` into it. An application-bank erase sets it back to 0xFF; a loader-bank erase leaves it unchanged.
- R9: While security bit 0 is 0, every read is refused with `err_o`, and `sec_o` reads 0x00.
- R10: While security bit 1 is 0, a read with `ext_fetch_i` high is refused with `err_o`. A read with `ext_fetch_i` low proceeds.
- R11: `sec_prog_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command start pulse |
| ctrl_i | input | 8 | Control byte: bank, enables, opcode |
| addr_i | input | 16 | Target byte address |
| wdata_i | input | 8 | Program data |
| ext_fetch_i | input | 1 | Requesting code runs from external memory |
| sec_prog_i | input | 1 | Security register programming strobe |
| sec_wdata_i | input | 8 | Value ANDed into the security register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejected-command pulse |
| rdata_o | output | 8 | Last byte read |
| sec_o | output | 8 | Security register, reads 0x00 while locked |

## Verification
The bench sweeps all 256 control bytes. A decoder that misjudges any enable or opcode combination would start an operation where it should raise `err_o`, or the reverse. It fills and reads every address of both banks through two program passes. An overwrite instead of an AND, or a bank-select mix-up, shows up as wrong bytes read back. It also drives loader addresses with high bits set, where a missing wrap would reach the wrong byte or the wrong bank. It counts `busy_o` cycles for each operation to catch off-by-one timing. It then issues starts and security strobes while busy, and walks the security bits through the fetch guard, the loader erase that must not restore them, the lock and the restoring application erase.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_BAD   = 2'd3
  } flash_op_e;

  localparam logic [3:0] OPC_READ  = 4'b0000;
  localparam logic [3:0] OPC_PROG  = 4'b0001;
  localparam logic [3:0] OPC_ERASE = 4'b0010;
  localparam int unsigned NBANK    = 2;
endpackage

// File: rtl/flash_cmd_dec.sv
module flash_cmd_dec
  import flash_seq_pkg::*;
(
  input  logic [7:0] ctrl_i,
  output flash_op_e  op_o,
  output logic       bank_o
);
  logic oe, ce;
  logic unused_rsvd;
  assign oe          = ctrl_i[5];
  assign ce          = ctrl_i[4];
  assign bank_o      = ctrl_i[6];
  assign unused_rsvd = ctrl_i[7];

  always_comb begin
    op_o = OP_BAD;
    unique case (ctrl_i[3:0])
      OPC_ERASE: if (oe && !ce)  op_o = OP_ERASE;
      OPC_PROG:  if (oe && !ce)  op_o = OP_PROG;
      OPC_READ:  if (!oe && !ce) op_o = OP_READ;
      default:   op_o = OP_BAD;
    endcase
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             busy_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign fire_o = busy_o && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_o <= 1'b0;
    end else if (load_i && !busy_o) begin
      cnt_q  <= dur_i;
      busy_o <= 1'b1;
    end else if (busy_o) begin
      cnt_q  <= cnt_q - CNT_W'(1);
      if (fire_o) busy_o <= 1'b0;
    end
  end

  assert_busy_from_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(load_i));
endmodule

// File: rtl/flash_bank.sv
module flash_bank #(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          erase_i,
  input  logic          prog_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_i) begin
      mem[addr_i] <= mem[addr_i] & wdata_i;
    end
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/flash_sec_reg.sv
module flash_sec_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prog_i,
  input  logic [7:0] wdata_i,
  input  logic       restore_i,
  output logic [7:0] sec_o
);
  // reset models a blank part
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        sec_o <= 8'hFF;
    else if (restore_i) sec_o <= 8'hFF;
    else if (prog_i)    sec_o <= sec_o & wdata_i;
  end

  assert_sec_only_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restore_i |=> ((sec_o & ~$past(sec_o)) == 8'h00));
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned MAIN_AW   = 10,
  parameter int unsigned LDR_AW    = 8,
  parameter int unsigned ERASE_CYC = 64,
  parameter int unsigned PROG_CYC  = 8,
  parameter int unsigned READ_CYC  = 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [7:0]  ctrl_i,
  input  logic [15:0] addr_i,
  input  logic [7:0]  wdata_i,
  input  logic        ext_fetch_i,
  input  logic        sec_prog_i,
  input  logic [7:0]  sec_wdata_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [7:0]  rdata_o,
  output logic [7:0]  sec_o
);
  localparam int unsigned MAX_EP  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned MAX_CYC = (MAX_EP > READ_CYC) ? MAX_EP : READ_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  flash_op_e        dec_op, op_q;
  logic             dec_bank, bank_q;
  logic [MAIN_AW-1:0] addr_q;
  logic [7:0]       wdata_q;
  logic [7:0]       sec_q;
  logic [CNT_W-1:0] dur;
  logic             go, denied, accept, fire;
  logic [7:0]       rd [NBANK];

  generate
    if (MAIN_AW < 16) begin : g_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr_i[15:MAIN_AW];
    end
  endgenerate

  flash_cmd_dec u_dec (.ctrl_i(ctrl_i), .op_o(dec_op), .bank_o(dec_bank));

  assign go     = start_i && !busy_o;
  assign denied = (dec_op == OP_READ) && (!sec_q[0] || (ext_fetch_i && !sec_q[1]));
  assign accept = go && (dec_op != OP_BAD) && !denied;

  always_comb begin
    unique case (dec_op)
      OP_ERASE: dur = CNT_W'(ERASE_CYC);
      OP_PROG:  dur = CNT_W'(PROG_CYC);
      default:  dur = CNT_W'(READ_CYC);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_READ;
      bank_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      op_q    <= dec_op;
      bank_q  <= dec_bank;
      addr_q  <= addr_i[MAIN_AW-1:0];
      wdata_q <= wdata_i;
    end
  end

  flash_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(accept), .dur_i(dur),
    .busy_o(busy_o), .fire_o(fire)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam int unsigned BAW = (b == 0) ? MAIN_AW : LDR_AW;
      logic sel;
      assign sel = (bank_q == b[0]);
      flash_bank #(.AW(BAW)) u_bank (
        .clk_i  (clk_i),
        .erase_i(fire && sel && (op_q == OP_ERASE)),
        .prog_i (fire && sel && (op_q == OP_PROG)),
        .addr_i (addr_q[BAW-1:0]),
        .wdata_i(wdata_q),
        .rdata_o(rd[b])
      );
    end
  endgenerate

  flash_sec_reg u_sec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prog_i   (sec_prog_i && !busy_o),
    .wdata_i  (sec_wdata_i),
    .restore_i(fire && (op_q == OP_ERASE) && !bank_q),
    .sec_o    (sec_q)
  );

  assign sec_o = sec_q[0] ? sec_q : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= fire;
      err_o  <= go && !accept;
      if (fire && (op_q == OP_READ)) rdata_o <= rd[bank_q];
    end
  end

  assert_err_leaves_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !busy_o);
  assert_done_at_busy_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $fell(busy_o));
  assert_rdata_on_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rdata_o) |-> done_o);
  assert_sec_hold_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !fire) |=> $stable(sec_q));
endmodule

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAW = 6, LAW = 4, ECYC = 12, PCYC = 4, RCYC = 2;
  localparam int MDEP = 1 << MAW, LDEP = 1 << LAW;

  logic clk = 0, rst_n = 0, start = 0, ext = 0, sprog = 0;
  logic [7:0] ctrl = 0, wdata = 0, swdata = 8'hFF;
  logic [15:0] addr = 0;
  logic busy_o, done_o, err_o;
  logic [7:0] rdata_o, sec_o;
  int checks = 0, fails = 0;
  logic [7:0] m_mem [MDEP];
  logic [7:0] l_mem [LDEP];

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_seq #(.MAIN_AW(MAW), .LDR_AW(LAW), .ERASE_CYC(ECYC), .PROG_CYC(PCYC),
    .READ_CYC(RCYC)) u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_i(ctrl), .addr_i(addr),
    .wdata_i(wdata), .ext_fetch_i(ext), .sec_prog_i(sprog), .sec_wdata_i(swdata),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o), .sec_o(sec_o));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [7:0] c, input logic [15:0] a, input logic [7:0] d, input logic e);
    ctrl = c; addr = a; wdata = d; ext = e; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic run(input logic [7:0] c, input logic [15:0] a, input logic [7:0] d,
                     input logic e, input int dur);
    int n = 0;
    issue(c, a, d, e);
    while (busy_o && n < 1000) begin n++; @(negedge clk); end
    check("R5 busy length", n, dur);
    check("R5 done pulse", done_o, 1);
  endtask

  task automatic rejected(input logic [7:0] c, input logic [15:0] a, input logic e, input string req);
    issue(c, a, 8'h00, e);
    check(req, err_o, 1);
    check(req, busy_o, 0);
    @(negedge clk);
    check(req, err_o, 0);
  endtask

  function automatic bit valid_ctrl(input logic [7:0] c);
    return ((c[3:0] == 4'd2 || c[3:0] == 4'd1) && c[5] && !c[4]) ||
           (c[3:0] == 4'd0 && !c[5] && !c[4]);
  endfunction

  function automatic logic [7:0] pat1(input int a); return 8'(a * 37 + 5) | 8'h81; endfunction
  function automatic logic [7:0] pat2(input int a); return 8'(a * 11) ^ 8'h5A; endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R5 reset busy", busy_o, 0);
    check("R5 reset done", done_o, 0);
    check("R1 reset err", err_o, 0);
    check("R8 reset sec", sec_o, 8'hFF);

    // R2 erase both banks, R3 program pass 1 and 2, R4 read back
    run(8'h22, 0, 0, 0, ECYC);
    run(8'h62, 0, 0, 0, ECYC);
    for (int a = 0; a < MDEP; a++) m_mem[a] = 8'hFF;
    for (int a = 0; a < LDEP; a++) l_mem[a] = 8'hFF;
    for (int a = 0; a < MDEP; a++) begin run(8'h00, 16'(a), 0, 0, RCYC); check("R2 main erased", rdata_o, 8'hFF); end
    for (int a = 0; a < LDEP; a++) begin run(8'h40, 16'(a), 0, 0, RCYC); check("R2 loader erased", rdata_o, 8'hFF); end
    for (int a = 0; a < MDEP; a++) begin run(8'h21, 16'(a), pat1(a), 0, PCYC); m_mem[a] &= pat1(a); end
    for (int a = 0; a < LDEP; a++) begin run(8'h61, 16'(a), pat2(a), 0, PCYC); l_mem[a] &= pat2(a); end
    for (int a = 0; a < MDEP; a++) begin run(8'h21, 16'(a), pat2(a), 0, PCYC); m_mem[a] &= pat2(a); end
    for (int a = 0; a < MDEP; a++) begin run(8'h00, 16'(a), 0, 0, RCYC); check("R3 main AND", rdata_o, m_mem[a]); end
    for (int a = 0; a < LDEP; a++) begin run(8'h40, 16'(a), 0, 0, RCYC); check("R4 loader read", rdata_o, l_mem[a]); end

    // R7 wrap: high address bits ignored
    for (int a = 0; a < LDEP; a++) begin
      run(8'h40, 16'(a) | 16'hF0A0 & ~16'(LDEP - 1), 0, 0, RCYC);
      check("R7 loader wrap", rdata_o, l_mem[a]);
    end
    run(8'h61, 16'h0FF3, 8'hF0, 0, PCYC); l_mem[3] &= 8'hF0;
    run(8'h40, 16'h0003, 0, 0, RCYC); check("R7 loader wrap program", rdata_o, l_mem[3]);
    run(8'h00, 16'h0003, 0, 0, RCYC); check("R7 main untouched", rdata_o, m_mem[3]);

    // R1 sweep every control byte; invalid ones are rejected, bit 7 ignored
    for (int c = 0; c < 256; c++) begin
      if (!valid_ctrl(8'(c))) rejected(8'(c), 16'h0005, 0, "R1 invalid ctrl");
    end
    run(8'h80, 16'h0005, 0, 0, RCYC); check("R1 bit7 ignored read", rdata_o, m_mem[5]);
    run(8'hC0, 16'h0007, 0, 0, RCYC); check("R1 loader after sweep", rdata_o, l_mem[7]);

    // R6 start during busy ignored; R11 sec strobe during busy ignored
    issue(8'h62, 0, 0, 0);
    ctrl = 8'h61; addr = 16'h0002; wdata = 8'h00; start = 1; sprog = 1; swdata = 8'h00;
    @(negedge clk);
    start = 0; sprog = 0; swdata = 8'hFF;
    check("R6 no err on busy start", err_o, 0);
    begin
      int n = 2;
      while (busy_o && n < 1000) begin n++; @(negedge clk); end
      check("R6 busy not extended", n, ECYC + 1);
    end
    check("R11 sec unchanged", sec_o, 8'hFF);
    @(negedge clk);
    check("R6 no requeue", busy_o, 0);
    for (int a = 0; a < LDEP; a++) l_mem[a] = 8'hFF;
    run(8'h40, 16'h0002, 0, 0, RCYC); check("R6 ignored program", rdata_o, 8'hFF);
    run(8'h00, 16'h0009, 0, 0, RCYC); check("R2 other bank kept", rdata_o, m_mem[9]);

    // R8/R10 security
    sprog = 1; swdata = 8'hFD; @(negedge clk); sprog = 0;
    check("R8 sec cleared", sec_o, 8'hFD);
    sprog = 1; swdata = 8'hFF; @(negedge clk); sprog = 0;
    check("R8 sec no set", sec_o, 8'hFD);
    rejected(8'h00, 16'h0004, 1, "R10 ext read refused");
    run(8'h00, 16'h0004, 0, 0, RCYC); check("R10 internal read ok", rdata_o, m_mem[4]);
    run(8'h62, 0, 0, 0, ECYC);
    check("R8 loader erase keeps sec", sec_o, 8'hFD);
    sprog = 1; swdata = 8'hFE; @(negedge clk); sprog = 0;
    check("R9 sec hidden", sec_o, 8'h00);
    rejected(8'h00, 16'h0004, 0, "R9 locked read");
    rejected(8'h40, 16'h0004, 0, "R9 locked loader read");
    run(8'h22, 0, 0, 0, ECYC);
    @(negedge clk);
    check("R8 main erase restores", sec_o, 8'hFF);
    run(8'h00, 16'h0004, 0, 1, RCYC); check("R2 main erased again", rdata_o, 8'hFF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule